// File: doc/BRIEF.md
# Privileged Next-PC and Exception Vector Unit

This block owns the program counter of a 32-bit core with two privilege levels. The level is the top bit of the PC: 0 means user mode and 1 means supervisor mode. Each cycle the block picks the next PC. The candidates are the sequential address, a branch target, a jump target, one of three fixed vectors, or the reset vector. It reports the choice as a 3-bit select code.

When a trap or an interrupt is taken, the block asks the register file to store the return address (PC+4) in the exception-return register. It also guards the address used for loads and stores. User code therefore never reaches the upper half of the address space, either by control flow or by data access. The only way into supervisor mode is through the reset, illegal-opcode or interrupt vectors.

Interrupt requests are captured at the clock edge. They are honoured only while the PC is in user mode, so handlers are never re-entered.

Top module: `pcx_ctl`

## Requirements
- R1: While `rst` is high, `pc_next_o` is 0x80000000, `pcsel_o` is 3'b000 and `xp_we_o` is 0. After a clock edge with `rst` high, `pc_o` is 0x80000000.
- R2: With no honoured interrupt and not in reset, `illop_i` gives `pc_next_o` = 0x80000004 and `pcsel_o` = 3'b011.
- R3: A honoured interrupt gives `pc_next_o` = 0x80000008 and `pcsel_o` = 3'b100.
- R4: An interrupt request is never honoured while `pc_o[31]` is 1. The request is dropped, and `pcsel_o` never reads 3'b100 in supervisor mode.
- R5: `irq_i` is sampled at each rising clock edge. A request seen at an edge acts in the following cycle only, judged against the `pc_o` of that cycle. A change of `irq_i` between edges has no effect on that cycle's outputs.
- R6: When an interrupt or an illegal opcode is taken, `xp_we_o` is 1 and `xp_wdata_o` is `pc_o`+4 in the same cycle. `xp_idx_o` is always 30. In every other cycle `xp_we_o` is 0.
- R7: The priority is reset, then honoured interrupt, then illegal opcode, then jump, then taken branch, then sequential.
- R8: A jump gives `pcsel_o` = 3'b010 and a taken branch gives 3'b001. In both cases `pc_next_o` is `target_i`, with bit 31 replaced by `pc_o[31]` AND `target_i[31]`. The sequential path gives 3'b000 and `pc_o`+4 under the same bit-31 rule.
- R9: From user mode, no branch, jump or sequential step sets bit 31. For example, 0x7FFFFFFC steps to 0x00000000, and a user jump to 0x90000010 lands at 0x10000010.
- R10: In supervisor mode, a jump or branch target passes unchanged, so it may clear bit 31 and return to user space.
- R11: `dmem_addr_o` equals `ls_addr_i`, except that bit 31 is forced to 0 while `pc_o[31]` is 0.
- R12: At every rising edge without reset, `pc_o` takes the value that `pc_next_o` showed before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt request, sampled at the clock edge |
| illop_i | input | 1 | Current instruction is illegal (trap) |
| jmp_i | input | 1 | Current instruction is a jump |
| br_taken_i | input | 1 | Current instruction is a taken branch |
| target_i | input | 32 | Branch or jump target address |
| ls_addr_i | input | 32 | Raw load/store address |
| pc_o | output | 32 | Registered current PC; bit 31 is the mode |
| pc_next_o | output | 32 | PC chosen for the next cycle |
| pcsel_o | output | 3 | Next-PC source code |
| xp_we_o | output | 1 | Write enable for the exception-return register |
| xp_idx_o | output | 5 | Index of the exception-return register |
| xp_wdata_o | output | 32 | Return address to store (PC+4) |
| dmem_addr_o | output | 32 | Guarded load/store address |

## Verification
The outputs `pc_next_o`, `pcsel_o`, `xp_we_o`, `xp_wdata_o` and `dmem_addr_o` follow the inputs and `pc_o` within the same cycle. The bench drives inputs after the falling edge and reads these outputs 2 ns later, well before the next rising edge. `pc_o` changes one edge after the choice, so it is read 1 ns after the edge and again at the start of the next step. An interrupt acts one edge after it is seen. The bench therefore keeps a sampled copy of the request from the previous edge. Against that copy it checks both the cycle in which the request is raised, where nothing must happen, and the cycle that follows.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  typedef enum logic [2:0] {
    SEL_SEQ = 3'b000,
    SEL_BR  = 3'b001,
    SEL_JMP = 3'b010,
    SEL_ILL = 3'b011,
    SEL_IRQ = 3'b100
  } pcsel_e;
endpackage

// File: rtl/pcx_irq_sample.sv
module pcx_irq_sample #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  output logic irq_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= irq_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], irq_i};
      end
    end
  endgenerate

  assign irq_o = sh_q[STAGES-1];
endmodule

// File: rtl/pcx_guard.sv
module pcx_guard #(
  parameter int XLEN = 32
) (
  input  logic            mode_i,
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] safe_o
);
  assign safe_o = {mode_i & raw_i[XLEN-1], raw_i[XLEN-2:0]};
endmodule

// File: rtl/pcx_select.sv
module pcx_select
  import pcx_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] RST_VEC = 32'h8000_0000,
  parameter logic [XLEN-1:0] ILL_VEC = 32'h8000_0004,
  parameter logic [XLEN-1:0] IRQ_VEC = 32'h8000_0008
) (
  input  logic            rst,
  input  logic            irq_ok_i,
  input  logic            illop_i,
  input  logic            jmp_i,
  input  logic            br_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] tgt_i,
  output logic [XLEN-1:0] next_o,
  output pcsel_e          sel_o,
  output logic            xwe_o
);
  always_comb begin
    next_o = seq_i;
    sel_o  = SEL_SEQ;
    xwe_o  = 1'b0;
    if (rst) begin
      next_o = RST_VEC;
    end else if (irq_ok_i) begin
      next_o = IRQ_VEC;
      sel_o  = SEL_IRQ;
      xwe_o  = 1'b1;
    end else if (illop_i) begin
      next_o = ILL_VEC;
      sel_o  = SEL_ILL;
      xwe_o  = 1'b1;
    end else if (jmp_i) begin
      next_o = tgt_i;
      sel_o  = SEL_JMP;
    end else if (br_i) begin
      next_o = tgt_i;
      sel_o  = SEL_BR;
    end
  end
endmodule

// File: rtl/pcx_ctl.sv
module pcx_ctl
  import pcx_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              RIDX_W     = 5,
  parameter int              XP_IDX     = 30,
  parameter int              IRQ_STAGES = 1,
  parameter logic [XLEN-1:0] RST_VEC    = 32'h8000_0000,
  parameter logic [XLEN-1:0] ILL_VEC    = 32'h8000_0004,
  parameter logic [XLEN-1:0] IRQ_VEC    = 32'h8000_0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_i,
  input  logic              illop_i,
  input  logic              jmp_i,
  input  logic              br_taken_i,
  input  logic [XLEN-1:0]   target_i,
  input  logic [XLEN-1:0]   ls_addr_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   pc_next_o,
  output logic [2:0]        pcsel_o,
  output logic              xp_we_o,
  output logic [RIDX_W-1:0] xp_idx_o,
  output logic [XLEN-1:0]   xp_wdata_o,
  output logic [XLEN-1:0]   dmem_addr_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_inc, seq_safe, tgt_safe, nxt;
  logic            irq_s, irq_ok, sup;
  pcsel_e          sel;

  assign sup    = pc_q[XLEN-1];
  assign pc_inc = pc_q + STEP;

  pcx_irq_sample #(.STAGES(IRQ_STAGES)) u_irq (
    .clk(clk), .rst(rst), .irq_i(irq_i), .irq_o(irq_s)
  );

  assign irq_ok = irq_s & ~sup;

  pcx_guard #(.XLEN(XLEN)) u_seq_g (.mode_i(sup), .raw_i(pc_inc),    .safe_o(seq_safe));
  pcx_guard #(.XLEN(XLEN)) u_tgt_g (.mode_i(sup), .raw_i(target_i),  .safe_o(tgt_safe));
  pcx_guard #(.XLEN(XLEN)) u_dat_g (.mode_i(sup), .raw_i(ls_addr_i), .safe_o(dmem_addr_o));

  pcx_select #(
    .XLEN(XLEN), .RST_VEC(RST_VEC), .ILL_VEC(ILL_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_sel (
    .rst(rst), .irq_ok_i(irq_ok), .illop_i(illop_i), .jmp_i(jmp_i),
    .br_i(br_taken_i), .seq_i(seq_safe), .tgt_i(tgt_safe),
    .next_o(nxt), .sel_o(sel), .xwe_o(xp_we_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RST_VEC;
    else     pc_q <= nxt;
  end

  assign pc_o       = pc_q;
  assign pc_next_o  = nxt;
  assign pcsel_o    = sel;
  assign xp_wdata_o = pc_inc;
  assign xp_idx_o   = RIDX_W'(XP_IDX);
endmodule

// File: rtl/pcx_ctl_chk.sv
module pcx_ctl_chk #(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] RST_VEC = 32'h8000_0000
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] pc_next_o,
  input logic [2:0]      pcsel_o,
  input logic            xp_we_o,
  input logic [XLEN-1:0] xp_wdata_o,
  input logic [XLEN-1:0] dmem_addr_o
);
  AST_RESET_VECTOR: assert property (@(posedge clk)
    rst |=> pc_o == RST_VEC); // R1

  AST_NO_IRQ_IN_SUP: assert property (@(posedge clk) disable iff (rst)
    pc_o[XLEN-1] |-> pcsel_o != 3'b100); // R4

  AST_IRQ_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    pcsel_o == 3'b100 |-> $past(irq_i)); // R5

  AST_XP_RETURN: assert property (@(posedge clk) disable iff (rst)
    xp_we_o |-> xp_wdata_o == pc_o + XLEN'(4)); // R6

  AST_USER_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!pc_o[XLEN-1] && pcsel_o != 3'b100 && pcsel_o != 3'b011) |=> !pc_o[XLEN-1]); // R9

  AST_DATA_GUARD: assert property (@(posedge clk) disable iff (rst)
    !pc_o[XLEN-1] |-> !dmem_addr_o[XLEN-1]); // R11

  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_o == $past(pc_next_o)); // R12
endmodule

bind pcx_ctl pcx_ctl_chk #(.XLEN(XLEN), .RST_VEC(RST_VEC)) u_chk (
  .clk(clk), .rst(rst), .irq_i(irq_i), .pc_o(pc_o), .pc_next_o(pc_next_o),
  .pcsel_o(pcsel_o), .xp_we_o(xp_we_o), .xp_wdata_o(xp_wdata_o),
  .dmem_addr_o(dmem_addr_o)
);

// File: tb/tb_pcx_ctl.sv
`timescale 1ns/1ps
module tb_pcx_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_i = 1'b0, illop_i = 1'b0, jmp_i = 1'b0, br_taken_i = 1'b0;
  logic [31:0] target_i = '0, ls_addr_i = '0;
  logic [31:0] pc_o, pc_next_o, xp_wdata_o, dmem_addr_o;
  logic [2:0]  pcsel_o;
  logic        xp_we_o;
  logic [4:0]  xp_idx_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_pc = 32'h8000_0000;
  logic        m_irq = 1'b0;
  logic [2:0]  last_sel;

  always #10 clk = ~clk;

  pcx_ctl dut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .illop_i(illop_i), .jmp_i(jmp_i),
    .br_taken_i(br_taken_i), .target_i(target_i), .ls_addr_i(ls_addr_i),
    .pc_o(pc_o), .pc_next_o(pc_next_o), .pcsel_o(pcsel_o), .xp_we_o(xp_we_o),
    .xp_idx_o(xp_idx_o), .xp_wdata_o(xp_wdata_o), .dmem_addr_o(dmem_addr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] guard(input logic mode, input logic [31:0] a);
    return {mode & a[31], a[30:0]};
  endfunction

  // expected decision from the requirements (R1..R10)
  function automatic void expect_next(input logic r, input logic iq, input logic [31:0] pc,
      input logic il, input logic jp, input logic br, input logic [31:0] tg,
      output logic [31:0] nx, output logic [2:0] sel, output logic we, output string req);
    logic sup = pc[31];
    we = 1'b0;
    if (r)                begin nx = 32'h8000_0000; sel = 3'b000; req = "R1"; end
    else if (iq && !sup)  begin nx = 32'h8000_0008; sel = 3'b100; we = 1'b1; req = "R3"; end
    else if (il)          begin nx = 32'h8000_0004; sel = 3'b011; we = 1'b1; req = "R2"; end
    else if (jp)          begin nx = guard(sup, tg); sel = 3'b010; req = sup ? "R10" : "R8"; end
    else if (br)          begin nx = guard(sup, tg); sel = 3'b001; req = sup ? "R10" : "R8"; end
    else                  begin nx = guard(sup, pc + 32'd4); sel = 3'b000; req = "R9"; end
  endfunction

  task automatic step(input logic r, input logic iq, input logic il, input logic jp,
                      input logic br, input logic [31:0] tg, input logic [31:0] ls);
    logic [31:0] nx; logic [2:0] sel; logic we; string req;
    @(negedge clk);
    rst = r; irq_i = iq; illop_i = il; jmp_i = jp; br_taken_i = br;
    target_i = tg; ls_addr_i = ls;
    #2;
    chk(pc_o === m_pc, "R12 pc_o", pc_o, m_pc);
    expect_next(r, m_irq, m_pc, il, jp, br, tg, nx, sel, we, req);
    chk(pc_next_o === nx, {req, " R7 pc_next"}, pc_next_o, nx);
    chk(pcsel_o === sel, {req, " R7 pcsel"}, {29'd0, pcsel_o}, {29'd0, sel});
    chk(xp_we_o === we, "R6 xp_we", {31'd0, xp_we_o}, {31'd0, we});
    if (we) chk(xp_wdata_o === m_pc + 32'd4, "R6 xp_wdata", xp_wdata_o, m_pc + 32'd4);
    chk(xp_idx_o === 5'd30, "R6 xp_idx", {27'd0, xp_idx_o}, 32'd30);
    chk(dmem_addr_o === guard(m_pc[31], ls), "R11 dmem_addr", dmem_addr_o, guard(m_pc[31], ls));
    last_sel = pcsel_o;
    @(posedge clk);
    m_irq = r ? 1'b0 : iq;
    m_pc  = r ? 32'h8000_0000 : nx;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 1, 32'h1234_5678, 0);
    chk(pc_o === 32'h8000_0000, "R1 reset pc", pc_o, 32'h8000_0000);
    // supervisor data access passes unchanged
    step(0, 0, 0, 0, 0, 0, 32'hF000_0000);
    chk(pc_o === 32'h8000_0004, "R9 sup step", pc_o, 32'h8000_0004);
    // supervisor jump to user space
    step(0, 0, 0, 1, 0, 32'h7FFF_FFFC, 0);
    chk(pc_o === 32'h7FFF_FFFC, "R10 return to user", pc_o, 32'h7FFF_FFFC);
    step(0, 0, 0, 0, 0, 0, 32'hF000_0000);
    chk(pc_o === 32'h0000_0000, "R9 wrap stays user", pc_o, 32'h0);
    step(0, 0, 0, 1, 0, 32'h9000_0010, 0);
    chk(pc_o === 32'h1000_0010, "R9 user jump masked", pc_o, 32'h1000_0010);
    step(0, 0, 0, 0, 1, 32'hC000_0020, 0);
    chk(pc_o === 32'h4000_0020, "R9 user branch masked", pc_o, 32'h4000_0020);
    // interrupt raised between edges: no effect this cycle
    step(0, 1, 0, 0, 0, 0, 0);
    chk(last_sel === 3'b000, "R5 no effect same cycle", {29'd0, last_sel}, 32'd0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(last_sel === 3'b100, "R5 acts next cycle", {29'd0, last_sel}, 32'd4);
    chk(pc_o === 32'h8000_0008, "R3 irq vector", pc_o, 32'h8000_0008);
    // interrupt in supervisor ignored
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(last_sel === 3'b000, "R4 sup irq ignored", {29'd0, last_sel}, 32'd0);
    chk(pc_o === 32'h8000_0010, "R4 sup pc", pc_o, 32'h8000_0010);
    // priority: irq over illop/jump/branch
    step(0, 0, 0, 1, 0, 32'h0000_0100, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 32'h0000_0200, 0);
    chk(last_sel === 3'b100, "R7 irq wins", {29'd0, last_sel}, 32'd4);
    step(0, 0, 1, 1, 1, 32'h0000_0200, 0);
    chk(last_sel === 3'b011, "R2 illop wins over jump", {29'd0, last_sel}, 32'd3);
    chk(pc_o === 32'h8000_0004, "R2 illop vector", pc_o, 32'h8000_0004);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] tg;
      tg = $urandom;
      step(($urandom % 300) == 0, ($urandom % 6) == 0, ($urandom % 14) == 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0, tg, $urandom);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule